// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block is the operand stack of a zero-address arithmetic unit. Commands arrive one at a time over a valid/ready handshake. A command either pushes a data word or combines the two uppermost entries with add, subtract, multiply or divide. The logical stack has no fixed bound. Only its uppermost `NREG` entries sit in a register window; everything deeper lives in an external synchronous memory. The current top entry is always visible on `tos`.

Memory is touched only when the window overflows or runs short. A push onto a full window first writes the deepest window entry out to the spill area. An arithmetic command shrinks the stack by one. If spilled entries remain after it, the block reads the most recently spilled one back so that the window is full again. While either transfer is in progress the block holds its command input off. Two counters record how many implicit stores and fetches have happened since reset. A sticky flag reports an arithmetic command issued with fewer than two entries on the stack.

Top module: `evs_stack`

## Requirements
- R1: While reset is held and in the first cycle after it, `depth` reads 0, `cmd_ready` is 1, both reference counters read 0, `underflow_err` is 0 and `mem_req` is 0.
- R2: A push (`cmd_op` = 0) accepted with `depth` below `NREG` makes `tos` equal to `cmd_data` and raises `depth` by one. It issues no memory request and `cmd_ready` stays high in the following cycle.
- R3: A push accepted with `depth` at least `NREG` places `cmd_data` on top. In the next cycle it issues exactly one write (`mem_req`=1, `mem_we`=1) of the deepest window entry to address `MEM_BASE + k`, where k is the number of entries already spilled. `cmd_ready` is low for that one cycle and `store_count` rises by one.
- R4: Codes 1, 2, 3 and 4 select add, subtract, multiply and divide. Each is applied as (second entry) OP (top entry) on unsigned values modulo 2^DW, the product keeping its low DW bits. Division by zero yields all ones. The result replaces both operands, so `depth` drops by one.
- R5: An arithmetic command accepted with `depth` above `NREG` issues, in the next cycle, one read (`mem_req`=1, `mem_we`=0) from address `MEM_BASE + k - 1`, where k is the spilled count before the command. `cmd_ready` stays low for two cycles and `fetch_count` rises by one. The word read back becomes the deepest window entry again.
- R6: An arithmetic command accepted with `depth` below 2 sets `underflow_err`, which then stays set until reset. It leaves `depth`, `tos` and the memory port untouched.
- R7: Command codes 5, 6 and 7 are accepted and change nothing.
- R8: Memory is referenced only in the cases of R3 and R5. With `NREG`=4 and an empty stack, the sequence a b c * + a d c * + e - / costs no references. Started on a stack that already holds two entries, the same sequence costs 4 stores and 4 fetches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_op | input | 3 | Command code: 0 push, 1 add, 2 sub, 3 mul, 4 div |
| cmd_data | input | DW | Value for a push |
| tos | output | DW | Current top-of-stack value |
| depth | output | AW+2 | Logical stack depth |
| underflow_err | output | 1 | Sticky: arithmetic attempted with fewer than two entries |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | 1 for a spill write, 0 for a refill read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Spilled value |
| mem_rdata | input | DW | Read data, valid the cycle after a read strobe |
| store_count | output | CNTW | Implicit stores since reset |
| fetch_count | output | CNTW | Implicit fetches since reset |

## Verification
On every cycle, the assertions check the handshake timing around spills and refills and the one-step depth changes. They also check the sticky error, the fact that memory strobes occur only while commands are held off, and the counter steps. Only the bench's scenarios can show the rest. That covers operand order and the divide-by-zero value, the spill and refill addresses, and the round trip of spilled values back to the top. It also covers the exact reference counts for a full reverse-Polish expression.

// File: rtl/evs_pkg.sv
`timescale 1ns/1ps
package evs_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4
  } evs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPILL,
    ST_FREQ,
    ST_FWAIT
  } evs_state_e;
endpackage

// File: rtl/evs_alu.sv
`timescale 1ns/1ps
// Combinational operator: lhs is the entry below the top, rhs the top.
module evs_alu #(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] res
);
  import evs_pkg::*;

  always_comb begin
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      OP_DIV:  res = (rhs == '0) ? '1 : lhs / rhs;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/evs_window.sv
`timescale 1ns/1ps
// Register window: slot 0 is the top, slot NREG-1 the deepest held entry.
module evs_window #(
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_en,
  input  logic [DW-1:0]              push_data,
  input  logic                       red_en,
  input  logic [DW-1:0]              red_data,
  input  logic                       fill_en,
  input  logic [DW-1:0]              fill_data,
  output logic [$clog2(NREG+1)-1:0]  cnt,
  output logic [DW-1:0]              top,
  output logic [DW-1:0]              second,
  output logic [DW-1:0]              bottom
);
  localparam int CW = $clog2(NREG + 1);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic [DW-1:0] q;
    if (i == 0) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)                            q <= '0;
        else if (push_en)                   q <= push_data;
        else if (red_en)                    q <= red_data;
        else if (fill_en && cnt == CW'(i))  q <= fill_data;
      end
    end else if (i == NREG - 1) begin : g_last
      always_ff @(posedge clk) begin
        if (rst)                            q <= '0;
        else if (push_en)                   q <= g_slot[i-1].q;
        else if (red_en)                    q <= '0;
        else if (fill_en && cnt == CW'(i))  q <= fill_data;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)                            q <= '0;
        else if (push_en)                   q <= g_slot[i-1].q;
        else if (red_en)                    q <= g_slot[i+1].q;
        else if (fill_en && cnt == CW'(i))  q <= fill_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                     cnt <= '0;
    else if (push_en && cnt != CW'(NREG))        cnt <= cnt + 1'b1;
    else if (red_en)                             cnt <= cnt - 1'b1;
    else if (fill_en)                            cnt <= cnt + 1'b1;
  end

  assign top    = g_slot[0].q;
  assign second = g_slot[1].q;
  assign bottom = g_slot[NREG-1].q;
endmodule

// File: rtl/evs_ctrl.sv
`timescale 1ns/1ps
// Command acceptance, spill/refill sequencing, depth tracking, counters.
module evs_ctrl #(
  parameter int          NREG     = 4,
  parameter int          DW       = 32,
  parameter int          AW       = 8,
  parameter int          CNTW     = 16,
  parameter int unsigned MEM_BASE = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(NREG+1)-1:0] win_cnt,
  input  logic [DW-1:0]             win_bottom,
  output logic                      cmd_ready,
  output logic                      push_en,
  output logic                      red_en,
  output logic                      fill_en,
  output logic [AW+1:0]             depth,
  output logic                      underflow_err,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [AW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  output logic [CNTW-1:0]           store_count,
  output logic [CNTW-1:0]           fetch_count
);
  import evs_pkg::*;
  localparam int CW = $clog2(NREG + 1);

  evs_state_e    state;
  logic [AW-1:0] msp;
  logic          fire, is_push, is_arith, uf, spill_now, fill_need;

  assign cmd_ready = (state == ST_IDLE);
  assign fill_en   = (state == ST_FWAIT);
  assign fire      = cmd_valid && cmd_ready;
  assign is_push   = (cmd_op == OP_PUSH);
  assign is_arith  = (cmd_op >= OP_ADD) && (cmd_op <= OP_DIV);
  assign push_en   = fire && is_push;
  assign uf        = fire && is_arith && (depth < (AW+2)'(2));
  assign red_en    = fire && is_arith && !uf;
  assign spill_now = push_en && (win_cnt == CW'(NREG));
  assign fill_need = red_en && (msp != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      msp           <= '0;
      depth         <= '0;
      underflow_err <= 1'b0;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      store_count   <= '0;
      fetch_count   <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (spill_now) begin
            mem_req     <= 1'b1;
            mem_we      <= 1'b1;
            mem_addr    <= AW'(MEM_BASE) + msp;
            mem_wdata   <= win_bottom;
            msp         <= msp + 1'b1;
            store_count <= store_count + 1'b1;
            state       <= ST_SPILL;
          end else if (fill_need) begin
            mem_req     <= 1'b1;
            mem_addr    <= AW'(MEM_BASE) + msp - 1'b1;
            msp         <= msp - 1'b1;
            fetch_count <= fetch_count + 1'b1;
            state       <= ST_FREQ;
          end
        end
        ST_SPILL: state <= ST_IDLE;
        ST_FREQ:  state <= ST_FWAIT;
        default:  state <= ST_IDLE;
      endcase
      if (push_en)     depth <= depth + 1'b1;
      else if (red_en) depth <= depth - 1'b1;
      if (uf) underflow_err <= 1'b1;
    end
  end
endmodule

// File: rtl/evs_stack.sv
`timescale 1ns/1ps
module evs_stack #(
  parameter int          DW       = 32,
  parameter int          NREG     = 4,
  parameter int          AW       = 8,
  parameter int          CNTW     = 16,
  parameter int unsigned MEM_BASE = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [DW-1:0]   cmd_data,
  output logic [DW-1:0]   tos,
  output logic [AW+1:0]   depth,
  output logic            underflow_err,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [CNTW-1:0] store_count,
  output logic [CNTW-1:0] fetch_count
);
  localparam int CW = $clog2(NREG + 1);

  logic [CW-1:0] win_cnt;
  logic [DW-1:0] win_second, win_bottom, alu_res;
  logic          push_en, red_en, fill_en;

  evs_alu #(.DW(DW)) u_alu (
    .op(cmd_op), .lhs(win_second), .rhs(tos), .res(alu_res)
  );

  evs_window #(.DW(DW), .NREG(NREG)) u_win (
    .clk(clk), .rst(rst),
    .push_en(push_en), .push_data(cmd_data),
    .red_en(red_en), .red_data(alu_res),
    .fill_en(fill_en), .fill_data(mem_rdata),
    .cnt(win_cnt), .top(tos), .second(win_second), .bottom(win_bottom)
  );

  evs_ctrl #(.NREG(NREG), .DW(DW), .AW(AW), .CNTW(CNTW), .MEM_BASE(MEM_BASE)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .win_cnt(win_cnt), .win_bottom(win_bottom),
    .cmd_ready(cmd_ready), .push_en(push_en), .red_en(red_en), .fill_en(fill_en),
    .depth(depth), .underflow_err(underflow_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .store_count(store_count), .fetch_count(fetch_count)
  );
endmodule

// File: rtl/evs_stack_chk.sv
`timescale 1ns/1ps
module evs_stack_chk #(
  parameter int DW   = 32,
  parameter int NREG = 4,
  parameter int AW   = 8,
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic [DW-1:0]   cmd_data,
  input logic [DW-1:0]   tos,
  input logic [AW+1:0]   depth,
  input logic            underflow_err,
  input logic            mem_req,
  input logic            mem_we,
  input logic [CNTW-1:0] store_count,
  input logic [CNTW-1:0] fetch_count
);
  logic fire, push_c, arith_c, other_c;
  assign fire    = cmd_valid && cmd_ready;
  assign push_c  = fire && (cmd_op == 3'd0);
  assign arith_c = fire && (cmd_op >= 3'd1) && (cmd_op <= 3'd4);
  assign other_c = fire && (cmd_op >= 3'd5);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (depth == '0 && store_count == '0 && fetch_count == '0 && !underflow_err && !mem_req));

  a_r2_plain_push: assert property (@(posedge clk) disable iff (rst)
    (push_c && depth < NREG) |=> (cmd_ready && !mem_req && tos == $past(cmd_data)));

  a_r3_spill_write: assert property (@(posedge clk) disable iff (rst)
    (push_c && depth >= NREG) |=> (mem_req && mem_we && !cmd_ready));

  a_r3_store_step: assert property (@(posedge clk) disable iff (rst)
    (push_c && depth >= NREG) |=> (store_count == $past(store_count) + 1'b1));

  a_r4_depth_drop: assert property (@(posedge clk) disable iff (rst)
    (arith_c && depth >= 2) |=> (depth == $past(depth) - 1'b1));

  a_r5_refill_read: assert property (@(posedge clk) disable iff (rst)
    (arith_c && depth > NREG) |=> (mem_req && !mem_we && !cmd_ready
                                   && fetch_count == $past(fetch_count) + 1'b1));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err);

  a_r6_no_change: assert property (@(posedge clk) disable iff (rst)
    (arith_c && depth < 2) |=> (underflow_err && $stable(depth) && $stable(tos) && !mem_req));

  a_r7_ignored: assert property (@(posedge clk) disable iff (rst)
    other_c |=> ($stable(depth) && $stable(tos) && !mem_req));

  a_r8_mem_while_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready);
endmodule

bind evs_stack evs_stack_chk #(.DW(DW), .NREG(NREG), .AW(AW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .tos(tos), .depth(depth),
  .underflow_err(underflow_err), .mem_req(mem_req), .mem_we(mem_we),
  .store_count(store_count), .fetch_count(fetch_count)
);

// File: tb/evs_stack_test.sv
`timescale 1ns/1ps
module evs_stack_test;
  localparam int DW = 32, NREG = 4, AW = 8, CNTW = 16;
  localparam int unsigned MEM_BASE = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [DW-1:0] cmd_data = '0;
  logic cmd_ready, underflow_err, mem_req, mem_we;
  logic [DW-1:0] tos, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW+1:0] depth;
  logic [AW-1:0] mem_addr;
  logic [CNTW-1:0] store_count, fetch_count;

  always #4 clk = ~clk;

  evs_stack #(.DW(DW), .NREG(NREG), .AW(AW), .CNTW(CNTW), .MEM_BASE(MEM_BASE)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .tos(tos), .depth(depth),
    .underflow_err(underflow_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .store_count(store_count), .fetch_count(fetch_count)
  );

  logic [DW-1:0] mem [256];
  always_ff @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  // Reference model: whole logical stack, q[0] is the bottom.
  logic [DW-1:0] q[$];
  int exp_st = 0, exp_fe = 0;
  bit exp_err = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] calc(logic [2:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      3'd1: return a + b;
      3'd2: return a - b;
      3'd3: return a * b;
      default: return (b == '0) ? '1 : a / b;
    endcase
  endfunction

  task automatic run(logic [2:0] op, logic [DW-1:0] d, string tag);
    int sz, busy, kind, addr_exp;
    logic [DW-1:0] swd, a, b;
    sz = q.size(); busy = 0; kind = 0; addr_exp = 0; swd = '0;
    if (op == 3'd0) begin
      if (sz >= NREG) begin
        busy = 1; kind = 1; addr_exp = MEM_BASE + sz - NREG; swd = q[sz-NREG]; exp_st++;
      end
      q.push_back(d);
    end else if (op <= 3'd4) begin
      if (sz < 2) exp_err = 1;
      else begin
        b = q.pop_back(); a = q.pop_back();
        q.push_back(calc(op, a, b));
        if (sz > NREG) begin
          busy = 2; kind = 2; addr_exp = MEM_BASE + sz - NREG - 1; exp_fe++;
        end
      end
    end
    @(negedge clk);
    chk(tag, "ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < busy; k++) begin
      chk(tag, "ready low while busy", cmd_ready, 0);
      if (k == 0) begin
        chk(tag, "mem_req", mem_req, 1);
        chk(tag, "mem_we", mem_we, (kind == 1));
        chk(tag, "mem_addr", mem_addr, addr_exp);
        if (kind == 1) chk(tag, "spilled value", mem_wdata, swd);
      end else chk(tag, "mem_req second cycle", mem_req, 0);
      @(negedge clk);
    end
    chk(tag, "ready after command", cmd_ready, 1);
    chk(tag, "no memory access", mem_req, 0);
    chk(tag, "depth", depth, q.size());
    if (q.size() > 0) chk(tag, "tos", tos, q[$]);
    chk(tag, "store_count", store_count, exp_st);
    chk(tag, "fetch_count", fetch_count, exp_fe);
    chk(tag, "underflow_err", underflow_err, exp_err);
  endtask

  task automatic rpn(string tag);
    run(0, 20, tag); run(0, 3, tag); run(0, 4, tag); run(3, 0, tag); run(1, 0, tag);
    run(0, 20, tag); run(0, 2, tag); run(0, 4, tag); run(3, 0, tag); run(1, 0, tag);
    run(0, 6, tag); run(2, 0, tag); run(4, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: held reset state
    chk("R1", "depth in reset", depth, 0);
    chk("R1", "ready in reset", cmd_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "depth", depth, 0);
    chk("R1", "ready", cmd_ready, 1);
    chk("R1", "store_count", store_count, 0);
    chk("R1", "fetch_count", fetch_count, 0);
    chk("R1", "underflow_err", underflow_err, 0);
    chk("R1", "mem_req", mem_req, 0);

    // R8: expression on an empty stack needs no references
    rpn("R8");
    chk("R8", "stores on empty start", store_count, 0);
    chk("R8", "fetches on empty start", fetch_count, 0);
    chk("R8", "expression result", tos, 1);
    // R8: same expression with two entries below costs 4 and 4
    run(0, 9, "R2");
    rpn("R8");
    chk("R8", "stores with two below", store_count, 4);
    chk("R8", "fetches with two below", fetch_count, 4);

    // R4: operand order for sub and div
    run(2, 0, "R4");
    run(4, 0, "R4");
    // R6: underflow with one entry
    run(1, 0, "R6");
    run(3, 0, "R6");
    // R7: reserved codes
    run(5, 32'h77, "R7");
    run(6, 32'h88, "R7");
    run(7, 32'h99, "R7");
    // R4: wrap on subtract, divide by zero, wide multiply
    run(0, 3, "R2"); run(0, 5, "R2"); run(2, 0, "R4");
    run(0, 0, "R2"); run(4, 0, "R4");
    run(0, 32'h0001_0003, "R2"); run(0, 32'h0002_0001, "R2"); run(3, 0, "R4");
    // R3 and R5: deep stack round trip
    for (int i = 1; i <= 9; i++) run(0, i * 7 + 1, "R3");
    run(3, 0, "R5"); run(1, 0, "R5"); run(2, 0, "R5"); run(4, 0, "R5");
    run(1, 0, "R5"); run(3, 0, "R5"); run(2, 0, "R5"); run(1, 0, "R5");
    run(1, 0, "R5"); run(2, 0, "R5"); run(1, 0, "R5");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule